// File: doc/BRIEF.md
# Long Copy Request Segmenter

This block takes a single memory-to-memory copy request (source address, destination address and a byte length) and feeds it to a downstream copy engine whose length field is only 28 bits wide. A request longer than the engine can take in one go is cut into consecutive segments. Every segment except the last carries the largest length the engine accepts, 2^28-1 bytes. The last segment carries what is left. The number of segments is the request length divided by that maximum, rounded up.

Segments are offered one at a time on a valid/ready command port. The block waits for the engine's per-segment done pulse before it offers the next one, so at most one segment is in flight. A residue count starts at the full request length and drops by a segment's length as that segment finishes. It is visible on an output at all times. A single completion pulse is raised for the whole request, and only once the residue has reached zero. A zero-length request completes at once and issues nothing.

Top module: `long_copy_segmenter`

## Requirements
- R1: After reset, req_ready is 1, cmd_valid is 0, req_done is 0 and residue is 0.
- R2: A request is taken only while the block is idle (req_ready high). While a request is in flight, req_ready is 0 and req_valid has no effect on the commands, the residue or completion.
- R3: A request of length L > 0 produces ceil(L / (2^28-1)) commands. Every command except the last has cmd_len = 2^28-1, and the last has the remainder. No command has length 0.
- R4: The first command carries the request's source and destination. Each later command's addresses equal the previous command's addresses plus the previous cmd_len, modulo 2^ADDR_W.
- R5: While cmd_valid is 1 and cmd_ready is 0, cmd_valid stays 1 and cmd_src, cmd_dst and cmd_len hold their values.
- R6: After a command is accepted (cmd_valid and cmd_ready both 1 at an edge), cmd_valid is 0 until seg_done is seen. The next command is offered in the cycle after that seg_done.
- R7: Residue equals the request length in the cycle after acceptance. It drops by the finished segment's length in the cycle after each seg_done, and is otherwise unchanged.
- R8: req_done is high for exactly one cycle, the cycle after the seg_done that brings the residue to zero. It stays low after every earlier seg_done.
- R9: A zero-length request raises req_done in the cycle after acceptance, issues no command and leaves the residue at 0.
- R10: seg_done while no segment is outstanding (idle, or a command still waiting for cmd_ready) has no effect on the residue, the command port or req_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Copy request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_src | input | ADDR_W | Request source address |
| req_dst | input | ADDR_W | Request destination address |
| req_len | input | LEN_W | Request length in bytes |
| cmd_valid | output | 1 | Segment command offered to the engine |
| cmd_ready | input | 1 | Engine takes the command |
| cmd_src | output | ADDR_W | Segment source address |
| cmd_dst | output | ADDR_W | Segment destination address |
| cmd_len | output | SEG_W | Segment length in bytes |
| seg_done | input | 1 | Engine finished the outstanding segment (pulse) |
| residue | output | LEN_W | Bytes of the request not yet finished |
| req_done | output | 1 | Whole request finished (one-cycle pulse) |

## Verification
On every cycle the assertions check several rules. A waiting command holds still. A command is followed by a gap with cmd_valid low. No command has length zero. The residue never grows during a request. Completion is only signalled with the residue at zero. The exact segment lengths, the address walk across segments and the point at which completion fires need the bench's scoreboard: it predicts the full segment list of each request, including single-segment, exact-boundary, seventeen-segment and address-wrapping requests. Only directed scenarios show that stray requests and stray done pulses are ignored, and that zero-length requests complete without issuing a command.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } lcs_state_e;
endpackage

// File: rtl/lcs_seg_sizer.sv
module lcs_seg_sizer #(
  parameter int LEN_W = 32,
  parameter int SEG_W = 28
) (
  input  logic [LEN_W-1:0] remain,
  output logic [SEG_W-1:0] seg_len
);
  localparam logic [SEG_W-1:0] SEG_MAX = {SEG_W{1'b1}};

  generate
    if (LEN_W > SEG_W) begin : g_clip
      localparam logic [LEN_W-1:0] SEG_MAX_W = LEN_W'(SEG_MAX);
      always_comb begin
        if (remain > SEG_MAX_W) seg_len = SEG_MAX;
        else                    seg_len = remain[SEG_W-1:0];
      end
    end else begin : g_pass
      always_comb seg_len = SEG_W'(remain);
    end
  endgenerate
endmodule

// File: rtl/lcs_addr_walker.sv
module lcs_addr_walker #(
  parameter int ADDR_W = 40,
  parameter int SEG_W  = 28,
  parameter int NPTR   = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load,
  input  logic                         step,
  input  logic [NPTR-1:0][ADDR_W-1:0]  start_addr,
  input  logic [SEG_W-1:0]             step_len,
  output logic [NPTR-1:0][ADDR_W-1:0]  cur_addr
);
  for (genvar i = 0; i < NPTR; i++) begin : g_ptr
    logic [ADDR_W-1:0] ptr_q, ptr_d;
    logic              ptr_en;

    always_comb begin
      ptr_en = load | step;
      ptr_d  = load ? start_addr[i] : ptr_q + ADDR_W'(step_len);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ptr_q <= '0;
      else if (ptr_en) ptr_q <= ptr_d;
    end

    assign cur_addr[i] = ptr_q;
  end
endmodule

// File: rtl/lcs_residue.sv
module lcs_residue #(
  parameter int LEN_W = 32,
  parameter int SEG_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_len,
  input  logic             retire,
  input  logic [SEG_W-1:0] retire_len,
  output logic [LEN_W-1:0] residue,
  output logic             last
);
  logic [LEN_W-1:0] res_q, res_d;
  logic             res_en;
  logic [LEN_W-1:0] retire_w;

  assign retire_w = LEN_W'(retire_len);

  always_comb begin
    res_en = load | retire;
    res_d  = load ? load_len : res_q - retire_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= '0;
    else if (res_en) res_q <= res_d;
  end

  assign residue = res_q;
  assign last    = (res_q == retire_w);

  AST_RES_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> res_q <= $past(res_q)); // R7
endmodule

// File: rtl/long_copy_segmenter.sv
module long_copy_segmenter #(
  parameter int ADDR_W = 40,
  parameter int LEN_W  = 32,
  parameter int SEG_W  = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_src,
  input  logic [ADDR_W-1:0] req_dst,
  input  logic [LEN_W-1:0]  req_len,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [ADDR_W-1:0] cmd_src,
  output logic [ADDR_W-1:0] cmd_dst,
  output logic [SEG_W-1:0]  cmd_len,
  input  logic              seg_done,
  output logic [LEN_W-1:0]  residue,
  output logic              req_done
);
  import lcs_pkg::*;

  localparam int NPTR = 2;

  lcs_state_e state_q, state_d;
  logic [LEN_W-1:0] remain_q, remain_d;
  logic [SEG_W-1:0] infl_q;
  logic             done_q, done_d;
  logic             load, issue, retire, zero_req;
  logic             res_last;
  logic [SEG_W-1:0] seg_len;
  logic [NPTR-1:0][ADDR_W-1:0] start_addr, cur_addr;

  // next-state logic
  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    issue    = 1'b0;
    retire   = 1'b0;
    zero_req = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (req_len == '0) zero_req = 1'b1;
          else begin
            load    = 1'b1;
            state_d = ST_ISSUE;
          end
        end
      end
      ST_ISSUE: begin
        if (cmd_ready) begin
          issue   = 1'b1;
          state_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (seg_done) begin
          retire  = 1'b1;
          state_d = res_last ? ST_IDLE : ST_ISSUE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    done_d   = zero_req | (retire & res_last);
    remain_d = load ? req_len : remain_q - LEN_W'(seg_len);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               remain_q <= '0;
    else if (load | issue)    remain_q <= remain_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      infl_q <= '0;
    else if (issue)  infl_q <= seg_len;
  end

  lcs_seg_sizer #(.LEN_W(LEN_W), .SEG_W(SEG_W)) u_sizer (
    .remain  (remain_q),
    .seg_len (seg_len)
  );

  assign start_addr[0] = req_src;
  assign start_addr[1] = req_dst;

  lcs_addr_walker #(.ADDR_W(ADDR_W), .SEG_W(SEG_W), .NPTR(NPTR)) u_walker (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .step       (issue),
    .start_addr (start_addr),
    .step_len   (seg_len),
    .cur_addr   (cur_addr)
  );

  lcs_residue #(.LEN_W(LEN_W), .SEG_W(SEG_W)) u_residue (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .load_len   (req_len),
    .retire     (retire),
    .retire_len (infl_q),
    .residue    (residue),
    .last       (res_last)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign cmd_valid = (state_q == ST_ISSUE);
  assign cmd_src   = cur_addr[0];
  assign cmd_dst   = cur_addr[1];
  assign cmd_len   = seg_len;
  assign req_done  = done_q;

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_src) && $stable(cmd_dst) && $stable(cmd_len)); // R5
  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_valid); // R6
  AST_SEG_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_len != '0); // R3
  AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |-> residue == '0); // R8
  AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !req_ready); // R2
endmodule

// File: tb/long_copy_segmenter_bench.sv
module long_copy_segmenter_bench;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 40;
  localparam int LEN_W  = 32;
  localparam int SEG_W  = 28;
  localparam longint SEG_MAX = (64'd1 << SEG_W) - 1;

  typedef struct {
    logic [ADDR_W-1:0] s;
    logic [ADDR_W-1:0] d;
    logic [SEG_W-1:0]  l;
  } seg_t;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, cmd_ready, seg_done;
  logic [ADDR_W-1:0] req_src, req_dst;
  logic [LEN_W-1:0]  req_len;
  logic req_ready, cmd_valid, req_done;
  logic [ADDR_W-1:0] cmd_src, cmd_dst;
  logic [SEG_W-1:0]  cmd_len;
  logic [LEN_W-1:0]  residue;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  seg_t exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  long_copy_segmenter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SEG_W(SEG_W)) u_long_copy_segmenter (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_src(req_src), .req_dst(req_dst), .req_len(req_len),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_src(cmd_src), .cmd_dst(cmd_dst), .cmd_len(cmd_len),
    .seg_done(seg_done), .residue(residue), .req_done(req_done)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: compare each accepted command with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && cmd_valid && cmd_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected command", 64'(cmd_len), 64'd0);
      end else begin
        seg_t e;
        e = exp_q.pop_front();
        chk(cmd_len == e.l, "R3 segment length", 64'(cmd_len), 64'(e.l));
        chk(cmd_src == e.s, "R4 segment source", 64'(cmd_src), 64'(e.s));
        chk(cmd_dst == e.d, "R4 segment destination", 64'(cmd_dst), 64'(e.d));
      end
    end
  end

  // driver: predicts the segments, then plays the engine
  task automatic run_req(input logic [ADDR_W-1:0] s, input logic [ADDR_W-1:0] d,
                         input logic [LEN_W-1:0] len, input int stall, input int gap,
                         input bit poke, input bit spur);
    longint left;
    longint exp_res;
    int nseg;
    logic [ADDR_W-1:0] ps, pd;
    seg_t e;
    left = longint'(len);
    ps = s; pd = d; nseg = 0;
    while (left > 0) begin
      e.s = ps; e.d = pd;
      e.l = (left > SEG_MAX) ? SEG_W'(SEG_MAX) : SEG_W'(left);
      exp_q.push_back(e);
      ps = ps + ADDR_W'(e.l); pd = pd + ADDR_W'(e.l);
      left = left - longint'(e.l);
      nseg++;
    end
    exp_res = longint'(len);

    @(posedge clk); #1;
    req_valid = 1'b1; req_src = s; req_dst = d; req_len = len;
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
    chk(64'(residue) == 64'(exp_res), "R7 residue loaded", 64'(residue), 64'(exp_res));
    if (len == '0) begin
      chk(req_done == 1'b1, "R9 zero-length done", 64'(req_done), 64'd1);
      chk(cmd_valid == 1'b0, "R9 no command", 64'(cmd_valid), 64'd0);
      @(negedge clk);
      chk(req_done == 1'b0, "R8 done is a pulse", 64'(req_done), 64'd0);
      return;
    end
    chk(req_ready == 1'b0, "R2 busy after accept", 64'(req_ready), 64'd0);
    for (int i = 0; i < nseg; i++) begin
      logic [ADDR_W-1:0] s0, d0;
      logic [SEG_W-1:0]  l0;
      logic [SEG_W-1:0]  this_len;
      this_len = (i == nseg-1) ? SEG_W'(longint'(len) - longint'(i) * SEG_MAX) : SEG_W'(SEG_MAX);
      chk(cmd_valid == 1'b1, "R6 command offered", 64'(cmd_valid), 64'd1);
      s0 = cmd_src; d0 = cmd_dst; l0 = cmd_len;
      for (int k = 0; k < stall; k++) begin
        @(posedge clk); #1;
        seg_done = (spur && k == 0);
        @(negedge clk);
        chk(cmd_valid && cmd_src == s0 && cmd_dst == d0 && cmd_len == l0,
            "R5 command held", 64'(cmd_len), 64'(l0));
        chk(64'(residue) == 64'(exp_res), "R10 stray done ignored", 64'(residue), 64'(exp_res));
        chk(req_done == 1'b0, "R10 no completion", 64'(req_done), 64'd0);
      end
      @(posedge clk); #1;
      seg_done = 1'b0; cmd_ready = 1'b1;
      @(posedge clk); #1;
      cmd_ready = 1'b0;
      if (poke) begin
        req_valid = 1'b1; req_src = 40'h12345; req_dst = 40'h6789; req_len = 32'd7;
      end
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        chk(cmd_valid == 1'b0, "R6 waits for done", 64'(cmd_valid), 64'd0);
        chk(req_ready == 1'b0, "R2 not ready in flight", 64'(req_ready), 64'd0);
        chk(64'(residue) == 64'(exp_res), "R2 residue untouched", 64'(residue), 64'(exp_res));
        @(posedge clk); #1;
      end
      req_valid = 1'b0;
      seg_done = 1'b1;
      @(posedge clk); #1;
      seg_done = 1'b0;
      exp_res = exp_res - longint'(this_len);
      @(negedge clk);
      chk(64'(residue) == 64'(exp_res), "R7 residue after segment", 64'(residue), 64'(exp_res));
      if (i == nseg-1) begin
        chk(req_done == 1'b1, "R8 done at zero", 64'(req_done), 64'd1);
        chk(req_ready == 1'b1, "R2 idle again", 64'(req_ready), 64'd1);
      end else begin
        chk(req_done == 1'b0, "R8 no early done", 64'(req_done), 64'd0);
      end
    end
    @(negedge clk);
    chk(req_done == 1'b0, "R8 done is a pulse", 64'(req_done), 64'd0);
    chk(exp_q.size() == 0, "R3 segment count", 64'(exp_q.size()), 64'd0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; cmd_ready = 1'b0; seg_done = 1'b0;
    req_src = '0; req_dst = '0; req_len = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 reset ready", 64'(req_ready), 64'd1);
    chk(cmd_valid == 1'b0, "R1 reset no command", 64'(cmd_valid), 64'd0);
    chk(req_done == 1'b0, "R1 reset no done", 64'(req_done), 64'd0);
    chk(residue == '0, "R1 reset residue", 64'(residue), 64'd0);

    // stray done while idle
    @(posedge clk); #1 seg_done = 1'b1;
    @(posedge clk); #1 seg_done = 1'b0;
    @(negedge clk);
    chk(residue == '0 && !req_done && !cmd_valid, "R10 idle stray done", 64'(residue), 64'd0);

    run_req(40'h00_1000_0000, 40'h00_2000_0000, 32'd100, 0, 1, 1'b0, 1'b0);
    run_req(40'h00_0000_0040, 40'h00_8000_0000, 32'h0FFF_FFFF, 1, 2, 1'b0, 1'b0);
    run_req(40'h00_0000_0000, 40'h10_0000_0000, 32'h1000_0000, 0, 1, 1'b0, 1'b0);
    run_req(40'h01_0000_0003, 40'h02_0000_0007, 32'h2FFF_FFFA, 2, 2, 1'b1, 1'b1);
    run_req(40'h55, 40'h66, 32'd0, 0, 1, 1'b0, 1'b0);
    run_req(40'hFF_F000_0000, 40'hFF_FFFF_FF00, 32'h2000_0000, 1, 1, 1'b0, 1'b0);
    run_req(40'h00_0000_1000, 40'h40_0000_0000, 32'hFFFF_FFFF, 0, 1, 1'b0, 1'b0);
    run_req(40'h77, 40'h88, 32'd1, 3, 3, 1'b1, 1'b1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule